// File: doc/BRIEF.md
# Strided and Indexed Vector Memory Unit

This unit turns one vector load or store into a series of element accesses on a single shared memory port. The active vector length is held in the unit. A set-length request writes it, and the unit clamps the value to the largest vector length it supports. A command supplies a base byte address and a stride counted in elements. It also selects either strided addressing or indexed addressing.

Elements are handled in groups whose size equals the lane count. For each group the unit asks the lanes for their operands: one index per lane, plus store data when the command is a store. For every lane it forms a byte address. The group's requests are placed in a request queue and sent to memory one at a time in ascending element order, using a ready/valid handshake. For a load, each returned word is steered to the lane slot it belongs to. When the whole group has arrived, the group is handed back to the lanes. The unit pulses a done strobe when the operation is finished.

Top module: `vmu_top`

## Requirements
- R1: In strided mode the request for element e carries byte address base + ((e * stride) << log2(DW/8)), taken modulo 2^AW. A negative stride is given in two's complement.
- R2: In indexed mode the request for element e carries byte address base + (idx << log2(DW/8)). Here idx is the lane operand that the lanes present for element e.
- R3: Requests leave one per handshake in strictly ascending element order. While mem_req_ready_i is low, a pending request keeps its valid, address, write flag and data unchanged.
- R4: Elements with an index at or above the active vector length produce no request. A command issued with a vector length of zero produces no request and still finishes with done_o.
- R5: A set-length request that arrives while the unit is idle loads min(len, MVL) into the vector length, and vl_o shows it. A set-length request that arrives while a command is running is ignored. After reset the vector length is MVL.
- R6: Operands are requested one group at a time: opnd_req_o is high for one cycle, and opnd_grp_o gives the group number. Groups run 0, 1, 2 and so on. Element e = group * L + lane.
- R7: Load responses arrive in request order. The k-th response of a group goes into lane k. When the group is complete, ld_valid_o pulses for one cycle. At that point ld_grp_o names the group, ld_mask_o sets bit i for each active lane, and lane i's word sits in ld_data_o bits [i*DW +: DW].
- R8: A store request has mem_req_we_o = 1 and carries the store operand of its element. A load request has mem_req_we_o = 0.
- R9: cmd_ready_o is high only while the unit is idle, and it is high after reset. done_o is high for exactly one cycle. For a store, that cycle follows the cycle in which the final write was accepted. For a load, it follows the final ld_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setvl_i | input | 1 | Set-length strobe |
| setvl_len_i | input | AW | Requested vector length |
| vl_o | output | $clog2(MVL+1) | Current vector length |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Unit idle, command accepted |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_indexed_i | input | 1 | 1 = indexed, 0 = strided |
| cmd_base_i | input | AW | Base byte address |
| cmd_stride_i | input | AW | Stride in elements |
| opnd_req_o | output | 1 | Operand fetch for a group |
| opnd_grp_o | output | $clog2(MVL) | Group being fetched or processed |
| opnd_idx_i | input | L*AW | Per-lane index operands |
| opnd_data_i | input | L*DW | Per-lane store operands |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | AW | Request byte address |
| mem_req_wdata_o | output | DW | Write data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_rdata_i | input | DW | Read response data |
| ld_valid_o | output | 1 | Load group complete |
| ld_grp_o | output | $clog2(MVL) | Group of returned load data |
| ld_mask_o | output | L | Active lanes of that group |
| ld_data_o | output | L*DW | Load data per lane |
| done_o | output | 1 | Operation finished |

## Verification
The first pattern is a full-length strided load with unit stride under an always-ready port. It shows that every group goes out in order and that each response lands in the correct lane. A store with stride 3 and a length that is not a multiple of the lane count shows whether the element index is scaled correctly and whether the trailing lanes are masked off. Indexed loads and stores use scrambled indices with a memory that stalls now and then. These runs tell the index path apart from the stride path and show whether a stalled request holds steady. A negative stride, a zero length, and a set-length request sent during a busy run cover wrap-around arithmetic, the empty command and the busy guard.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } vmu_state_e;
endpackage

// File: rtl/vmu_agu.sv
module vmu_agu #(
  parameter int unsigned L   = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned VLW = 5,
  parameter int unsigned GW  = 4,
  parameter int unsigned SH  = 2
) (
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   stride_i,
  input  logic            indexed_i,
  input  logic [GW-1:0]   grp_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [L*AW-1:0] idx_i,
  output logic [L*AW-1:0] addr_o,
  output logic [L-1:0]    act_o
);
  for (genvar g = 0; g < L; g++) begin : g_lane
    logic [AW-1:0] elem;
    logic [AW-1:0] off;
    assign elem = AW'(grp_i) * AW'(L) + AW'(g);
    // per-lane mux: indexed offset or scaled stride
    assign off = indexed_i ? idx_i[g*AW +: AW] : elem * stride_i;
    assign addr_o[g*AW +: AW] = base_i + (off << SH);
    assign act_o[g] = elem < AW'(vl_i);
  end
endmodule

// File: rtl/vmu_req_queue.sv
module vmu_req_queue #(
  parameter int unsigned L  = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [L-1:0]    act_i,
  input  logic [L*AW-1:0] addr_i,
  input  logic [L*DW-1:0] data_i,
  input  logic            pop_i,
  output logic            vld_o,
  output logic            last_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic [LW-1:0]   lane_o
);
  logic [L-1:0]  vld_q;
  logic [L-1:0]  head_oh;
  logic [AW-1:0] addr_q [L];
  logic [DW-1:0] data_q [L];

  always_comb begin
    head_oh = '0;
    lane_o  = '0;
    for (int i = L - 1; i >= 0; i--) begin
      if (vld_q[i]) begin
        head_oh = '0;
        head_oh[i] = 1'b1;
        lane_o = LW'(i);
      end
    end
  end

  assign vld_o  = |vld_q;
  assign last_o = (vld_q & ~head_oh) == '0;
  assign addr_o = addr_q[lane_o];
  assign data_o = data_q[lane_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (load_i) vld_q <= act_i;
    else if (pop_i)  vld_q <= vld_q & ~head_oh;
  end

  // write crossbar: lane operands gathered into queue slots
  for (genvar g = 0; g < L; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (load_i) begin
        addr_q[g] <= addr_i[g*AW +: AW];
        data_q[g] <= data_i[g*DW +: DW];
      end
    end
  end

  assert_pop_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> vld_o);
  assert_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !last_o) |=> (lane_o > $past(lane_o)));
  assert_fill_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !vld_o);
endmodule

// File: rtl/vmu_rd_xbar.sv
module vmu_rd_xbar #(
  parameter int unsigned L  = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            rsp_valid_i,
  input  logic [DW-1:0]   rsp_data_i,
  input  logic [CW-1:0]   n_i,
  output logic [CW-1:0]   cnt_o,
  output logic [L*DW-1:0] data_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (rsp_valid_i) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;

  // active lanes form a prefix, so response k belongs to lane k
  for (genvar g = 0; g < L; g++) begin : g_lane
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (rsp_valid_i && cnt_q == CW'(g)) word_q <= rsp_data_i;
    end
    assign data_o[g*DW +: DW] = word_q;
  end

  assert_rsp_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> (cnt_q < n_i));
endmodule

// File: rtl/vmu_top.sv
module vmu_top #(
  parameter int unsigned L   = 4,
  parameter int unsigned MVL = 16,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       setvl_i,
  input  logic [AW-1:0]              setvl_len_i,
  output logic [$clog2(MVL+1)-1:0]   vl_o,
  input  logic                       cmd_valid_i,
  output logic                       cmd_ready_o,
  input  logic                       cmd_store_i,
  input  logic                       cmd_indexed_i,
  input  logic [AW-1:0]              cmd_base_i,
  input  logic [AW-1:0]              cmd_stride_i,
  output logic                       opnd_req_o,
  output logic [$clog2(MVL)-1:0]     opnd_grp_o,
  input  logic [L*AW-1:0]            opnd_idx_i,
  input  logic [L*DW-1:0]            opnd_data_i,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic                       mem_req_we_o,
  output logic [AW-1:0]              mem_req_addr_o,
  output logic [DW-1:0]              mem_req_wdata_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [DW-1:0]              mem_rsp_rdata_i,
  output logic                       ld_valid_o,
  output logic [$clog2(MVL)-1:0]     ld_grp_o,
  output logic [L-1:0]               ld_mask_o,
  output logic [L*DW-1:0]            ld_data_o,
  output logic                       done_o
);
  import vmu_pkg::*;

  localparam int unsigned VLW = $clog2(MVL + 1);
  localparam int unsigned GW  = $clog2(MVL);
  localparam int unsigned LW  = $clog2(L);
  localparam int unsigned CW  = $clog2(L + 1);
  localparam int unsigned SH  = $clog2(DW / 8);

  vmu_state_e    st_q;
  logic [VLW-1:0] vl_q;
  logic          store_q, indexed_q;
  logic [AW-1:0] base_q, stride_q;
  logic [GW-1:0] grp_q;
  logic [CW-1:0] n_q;
  logic [L-1:0]  mask_q;

  logic [L*AW-1:0] lane_addr;
  logic [L-1:0]    lane_act;
  logic [CW-1:0]   n_act;
  logic [AW-1:0]   nxt_base;
  logic            more_grp;
  logic            q_vld, q_last, pop, fill;
  logic [AW-1:0]   q_addr;
  logic [DW-1:0]   q_data;
  logic [LW-1:0]   q_lane;
  logic [CW-1:0]   rsp_cnt;
  logic            grp_back;

  vmu_agu #(.L(L), .AW(AW), .VLW(VLW), .GW(GW), .SH(SH)) u_agu (
    .base_i   (base_q),
    .stride_i (stride_q),
    .indexed_i(indexed_q),
    .grp_i    (grp_q),
    .vl_i     (vl_q),
    .idx_i    (opnd_idx_i),
    .addr_o   (lane_addr),
    .act_o    (lane_act)
  );

  vmu_req_queue #(.L(L), .AW(AW), .DW(DW), .LW(LW)) u_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fill),
    .act_i  (lane_act),
    .addr_i (lane_addr),
    .data_i (opnd_data_i),
    .pop_i  (pop),
    .vld_o  (q_vld),
    .last_o (q_last),
    .addr_o (q_addr),
    .data_o (q_data),
    .lane_o (q_lane)
  );

  vmu_rd_xbar #(.L(L), .DW(DW), .CW(CW)) u_rxbar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (fill),
    .rsp_valid_i(mem_rsp_valid_i),
    .rsp_data_i (mem_rsp_rdata_i),
    .n_i        (n_q),
    .cnt_o      (rsp_cnt),
    .data_o     (ld_data_o)
  );

  always_comb begin
    n_act = '0;
    for (int i = 0; i < L; i++) n_act = n_act + CW'(lane_act[i]);
  end

  assign nxt_base = (AW'(grp_q) + AW'(1)) * AW'(L);
  assign more_grp = nxt_base < AW'(vl_q);
  assign fill     = (st_q == ST_FILL);
  assign pop      = mem_req_valid_o && mem_req_ready_i;
  assign grp_back = (st_q == ST_WAIT) && (rsp_cnt == n_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      vl_q      <= VLW'(MVL);
      store_q   <= 1'b0;
      indexed_q <= 1'b0;
      base_q    <= '0;
      stride_q  <= '0;
      grp_q     <= '0;
      n_q       <= '0;
      mask_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (setvl_i)
            vl_q <= (setvl_len_i > AW'(MVL)) ? VLW'(MVL) : VLW'(setvl_len_i);
          if (cmd_valid_i) begin
            store_q   <= cmd_store_i;
            indexed_q <= cmd_indexed_i;
            base_q    <= cmd_base_i;
            stride_q  <= cmd_stride_i;
            grp_q     <= '0;
            st_q      <= (vl_q == '0) ? ST_DONE : ST_FILL;
          end
        end
        ST_FILL: begin
          n_q    <= n_act;
          mask_q <= lane_act;
          st_q   <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (pop && q_last) begin
            if (!store_q)      st_q <= ST_WAIT;
            else if (more_grp) begin
              grp_q <= grp_q + 1'b1;
              st_q  <= ST_FILL;
            end else           st_q <= ST_DONE;
          end
        end
        ST_WAIT: begin
          if (grp_back) begin
            if (more_grp) begin
              grp_q <= grp_q + 1'b1;
              st_q  <= ST_FILL;
            end else st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vl_o            = vl_q;
  assign cmd_ready_o     = (st_q == ST_IDLE);
  assign opnd_req_o      = fill;
  assign opnd_grp_o      = grp_q;
  assign mem_req_valid_o = (st_q == ST_ISSUE) && q_vld;
  assign mem_req_we_o    = store_q;
  assign mem_req_addr_o  = q_addr;
  assign mem_req_wdata_o = q_data;
  assign ld_valid_o      = grp_back;
  assign ld_grp_o        = grp_q;
  assign ld_mask_o       = mask_q;
  assign done_o          = (st_q == ST_DONE);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)));
  assert_vl_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_q <= VLW'(MVL));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o));
  assert_mask_prefix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> (((ld_mask_o + 1'b1) & ld_mask_o) == '0 && ld_mask_o[0]));
  assert_rsp_loads_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> (!store_q && (st_q == ST_ISSUE || st_q == ST_WAIT)));
  assert_lane_in_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mask_q[q_lane]);
endmodule

// File: tb/tb_vmu_top.sv
module tb_vmu_top;
  localparam int L = 4;
  localparam int MVL = 16;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] MAGIC = 32'hA5A5_0F0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                setvl_i = 1'b0;
  logic [AW-1:0]       setvl_len_i = '0;
  logic [4:0]          vl_o;
  logic                cmd_valid_i = 1'b0, cmd_ready_o;
  logic                cmd_store_i = 1'b0, cmd_indexed_i = 1'b0;
  logic [AW-1:0]       cmd_base_i = '0, cmd_stride_i = '0;
  logic                opnd_req_o;
  logic [3:0]          opnd_grp_o;
  logic [L*AW-1:0]     opnd_idx_i;
  logic [L*DW-1:0]     opnd_data_i;
  logic                mem_req_valid_o, mem_req_ready_i = 1'b0, mem_req_we_o;
  logic [AW-1:0]       mem_req_addr_o;
  logic [DW-1:0]       mem_req_wdata_o;
  logic                mem_rsp_valid_i = 1'b0;
  logic [DW-1:0]       mem_rsp_rdata_i = '0;
  logic                ld_valid_o;
  logic [3:0]          ld_grp_o;
  logic [L-1:0]        ld_mask_o;
  logic [L*DW-1:0]     ld_data_o;
  logic                done_o;

  vmu_top #(.L(L), .MVL(MVL), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .setvl_i(setvl_i), .setvl_len_i(setvl_len_i), .vl_o(vl_o),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_store_i(cmd_store_i), .cmd_indexed_i(cmd_indexed_i),
    .cmd_base_i(cmd_base_i), .cmd_stride_i(cmd_stride_i),
    .opnd_req_o(opnd_req_o), .opnd_grp_o(opnd_grp_o),
    .opnd_idx_i(opnd_idx_i), .opnd_data_i(opnd_data_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_rdata_i(mem_rsp_rdata_i),
    .ld_valid_o(ld_valid_o), .ld_grp_o(ld_grp_o), .ld_mask_o(ld_mask_o),
    .ld_data_o(ld_data_o), .done_o(done_o)
  );

  int total = 0, bad = 0, cyc = 0;
  int vl_m = MVL;
  int exp_n = 0, ptr = 0, fills = 0, groups = 0, dones = 0;
  bit cur_store = 0, cur_idx = 0, stall_mode = 0;
  logic [31:0] exp_addr [MVL];
  logic [31:0] pend [$];

  function automatic logic [31:0] idx_of(int e);
    return 32'((e * 13 + 5) % 50);
  endfunction
  function automatic logic [31:0] sdata_of(int e);
    return 32'hD000_0000 | 32'(e * 17);
  endfunction

  // lanes: operands for the requested group
  always_comb begin
    for (int i = 0; i < L; i++) begin
      opnd_idx_i[i*AW +: AW]  = idx_of(int'(opnd_grp_o) * L + i);
      opnd_data_i[i*DW +: DW] = sdata_of(int'(opnd_grp_o) * L + i);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  // memory model and per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend.size() > 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_rdata_i = pend.pop_front() ^ MAGIC;
      end else begin
        mem_rsp_valid_i = 1'b0;
      end
      mem_req_ready_i = stall_mode ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (opnd_req_o) begin
        chk(int'(opnd_grp_o) == fills, "R6 operand group", 64'(opnd_grp_o), 64'(fills));
        fills++;
      end
      if (mem_req_valid_o) begin
        if (ptr >= exp_n) begin
          chk(0, "R4 request beyond vl", 64'(ptr), 64'(exp_n));
        end else begin
          chk(mem_req_addr_o == exp_addr[ptr], cur_idx ? "R2 indexed address" : "R1 strided address",
              64'(mem_req_addr_o), 64'(exp_addr[ptr]));
          chk(mem_req_we_o == cur_store, "R8 write flag", 64'(mem_req_we_o), 64'(cur_store));
          if (cur_store)
            chk(mem_req_wdata_o == sdata_of(ptr), "R8 store data", 64'(mem_req_wdata_o), 64'(sdata_of(ptr)));
          if (mem_req_ready_i) begin
            if (!cur_store) pend.push_back(mem_req_addr_o);
            ptr++;
          end
        end
      end
      if (ld_valid_o) begin
        int rem, nl;
        logic [L-1:0] em;
        rem = exp_n - groups * L;
        nl  = rem > L ? L : rem;
        em  = '0;
        for (int i = 0; i < nl; i++) em[i] = 1'b1;
        chk(int'(ld_grp_o) == groups, "R7 load group", 64'(ld_grp_o), 64'(groups));
        chk(ld_mask_o == em, "R7 load mask", 64'(ld_mask_o), 64'(em));
        for (int i = 0; i < nl; i++)
          chk(ld_data_o[i*DW +: DW] == (exp_addr[groups*L+i] ^ MAGIC), "R7 lane data",
              64'(ld_data_o[i*DW +: DW]), 64'(exp_addr[groups*L+i] ^ MAGIC));
        groups++;
      end
      if (done_o) begin
        int eg;
        eg = cur_store ? 0 : (exp_n + L - 1) / L;
        chk(ptr == exp_n, "R9 done after all requests", 64'(ptr), 64'(exp_n));
        chk(groups == eg, "R9 done after all load groups", 64'(groups), 64'(eg));
        dones++;
      end
    end
  end

  task automatic do_setvl(input int len);
    @(negedge clk);
    setvl_i = 1'b1;
    setvl_len_i = 32'(len);
    @(negedge clk);
    setvl_i = 1'b0;
  endtask

  task automatic start_cmd(input bit st, input bit ix, input logic [31:0] base, input logic [31:0] stride);
    exp_n = vl_m;
    for (int e = 0; e < MVL; e++)
      exp_addr[e] = ix ? base + (idx_of(e) << 2) : base + ((32'(e) * stride) << 2);
    ptr = 0; fills = 0; groups = 0; dones = 0;
    cur_store = st; cur_idx = ix;
    @(negedge clk);
    chk(cmd_ready_o == 1'b1, "R9 ready when idle", 64'(cmd_ready_o), 64'd1);
    cmd_valid_i = 1'b1; cmd_store_i = st; cmd_indexed_i = ix;
    cmd_base_i = base; cmd_stride_i = stride;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    #1;
    chk(cmd_ready_o == 1'b0, "R9 busy after accept", 64'(cmd_ready_o), 64'd0);
  endtask

  task automatic wait_done();
    while (dones == 0) @(negedge clk);
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, "R9 done single cycle", 64'(done_o), 64'd0);
    chk(cmd_ready_o == 1'b1, "R9 idle after done", 64'(cmd_ready_o), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cmd_ready_o == 1'b1, "R9 reset ready", 64'(cmd_ready_o), 64'd1);
    chk(mem_req_valid_o == 1'b0, "R9 reset no request", 64'(mem_req_valid_o), 64'd0);
    chk(done_o == 1'b0, "R9 reset done low", 64'(done_o), 64'd0);
    chk(vl_o == 5'(MVL), "R5 reset vl", 64'(vl_o), 64'(MVL));

    // full-length unit-stride load, always ready
    start_cmd(0, 0, 32'h0000_0100, 32'd1);
    wait_done();

    // partial group store, stride 3, stalls
    do_setvl(6); vl_m = 6;
    chk(vl_o == 5'd6, "R5 set vl", 64'(vl_o), 64'd6);
    stall_mode = 1;
    start_cmd(1, 0, 32'h0000_2000, 32'd3);
    wait_done();

    // indexed load with stalls
    do_setvl(5); vl_m = 5;
    start_cmd(0, 1, 32'h0001_0000, 32'd0);
    wait_done();

    // indexed store, full length
    do_setvl(16); vl_m = 16;
    start_cmd(1, 1, 32'h0003_0040, 32'd0);
    wait_done();

    // clamp above MVL
    do_setvl(40); vl_m = MVL;
    chk(vl_o == 5'(MVL), "R5 clamp to MVL", 64'(vl_o), 64'(MVL));

    // set-length while busy is ignored
    stall_mode = 0;
    start_cmd(0, 0, 32'h0000_0800, 32'd2);
    do_setvl(3);
    wait_done();
    chk(vl_o == 5'(MVL), "R5 busy set ignored", 64'(vl_o), 64'(MVL));

    // negative stride wraps
    do_setvl(4); vl_m = 4;
    start_cmd(0, 0, 32'h0000_0010, 32'hFFFF_FFFF);
    wait_done();

    // zero length: no requests, still done
    do_setvl(0); vl_m = 0;
    chk(vl_o == 5'd0, "R4 zero vl set", 64'(vl_o), 64'd0);
    start_cmd(1, 0, 32'h0000_4000, 32'd1);
    wait_done();
    chk(ptr == 0, "R4 zero vl no request", 64'(ptr), 64'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule